// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block sits on the bus-write side of a flash bank. It runs the multi-word buffered program command. The host issues a setup write, a word-count write carrying n, then n+1 address/data writes that fill a 32-entry write buffer, and finally a confirm write. The block checks that every write arrives in the right order. It also checks that every address stays inside the block chosen at setup and inside a window that runs from the first loaded address up to that address plus n.

A correct sequence ends with a one-cycle start pulse toward the array-program model. The pulse carries the start address and the count. The array model reads the buffered words through a small read port. A bad sequence, a bad address, or a confirm aimed at a protected block sets a sticky error flag and drops back to idle without any pulse.

During a program the ready flag stays low for a fixed number of cycles. In that time only the read-mode commands and the suspend command are honoured. A clear-status command removes sticky errors, but only while the bank is ready.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset, status reads 0x80, rd_mode is 0 and prog_start is low. Status bit 7 is ready, bit 4 is the sequence/address error and bit 1 is the protect error; all other status bits read 0.
- R2: While ready and idle, a write whose low data byte is 0xE8 starts a sequence at any address and latches that address's block (address bits [22:16]). rd_mode becomes 1 (status), and status bit 7 stays 1.
- R3: The count write must target the latched block and carry a value n below 32. Otherwise bit 4 is set and the sequence returns to idle.
- R4: Exactly n+1 load writes follow. The first load write's address becomes the start address. Every load address must lie in the latched block and in the window from start to start+n, or bit 4 is set and the sequence aborts. Each data word is stored at buffer index (address − start) and can be read back on buf_rd_data by driving buf_rd_idx.
- R5: A confirm write with low byte 0xD0 to the latched block produces prog_start high for exactly one cycle, with prog_addr equal to the start address and prog_count equal to n. Any other confirm data, or a confirm to another block, sets bit 4 and produces no pulse.
- R6: If prot_mask bit [block] is 1 at confirm, bit 1 is set, no pulse is given and the sequence returns to idle.
- R7: Status bit 7 goes low in the cycle in which prog_start is high and stays low for exactly PROG_CYCLES cycles.
- R8: While busy, only 0xFF (rd_mode 0), 0x70 (1), 0x90 (2), 0x98 (3) and 0xB0 (suspend, rd_mode 1) take effect. Every other write, including 0xE8 and 0x50, is ignored.
- R9: Bits 4 and 1 stay set until a 0x50 write arrives while idle. That write clears both bits.
- R10: While idle, 0xFF, 0x70, 0x90 and 0x98 set rd_mode to 0, 1, 2 and 3. Other codes leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W (23) | Bus write word address |
| wr_data | input | DATA_W (16) | Bus write data or command code (low byte) |
| prot_mask | input | 2^(ADDR_W-BLK_SHIFT) (128) | Per-block protect bits |
| buf_rd_idx | input | 5 | Write-buffer read index from the array model |
| buf_rd_data | output | DATA_W (16) | Write-buffer word at buf_rd_idx |
| status | output | 8 | Status register |
| rd_mode | output | 2 | What bank reads return: 0 array, 1 status, 2 signature, 3 query |
| prog_start | output | 1 | One-cycle program start pulse |
| prog_addr | output | ADDR_W (23) | Start address of the programmed run |
| prog_count | output | 5 | n, where n+1 words are programmed |

## Verification
The assertions assume that prot_mask is held steady from a confirm until the following start pulse has been seen. They also assume that wr_en is never undefined after reset. The bench changes the protect bits only while the sequencer is idle, and it always drives full-width defined values. It sweeps every legal count from 0 to 31, loading the words out of order within the window. It then aims single faults at each phase: an oversized count, a foreign block, addresses just past each end of the window, wrong confirm data and a protected target.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_COUNT, ST_LOAD, ST_CONFIRM, ST_BUSY
   } fbp_state_e;

   typedef enum logic [1:0] {
      RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_SIGN = 2'd2, RM_QUERY = 2'd3
   } fbp_rmode_e;

   localparam logic [7:0] CMD_SETUP   = 8'hE8;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;
   localparam logic [7:0] CMD_CLEAR   = 8'h50;
   localparam logic [7:0] CMD_ARRAY   = 8'hFF;
   localparam logic [7:0] CMD_STATUS  = 8'h70;
   localparam logic [7:0] CMD_SIGN    = 8'h90;
   localparam logic [7:0] CMD_QUERY   = 8'h98;
   localparam logic [7:0] CMD_SUSPEND = 8'hB0;

   localparam int SR_READY = 7;
   localparam int SR_SEQ   = 4;
   localparam int SR_PROT  = 1;
endpackage

// File: rtl/fbp_addr_window.sv
module fbp_addr_window #(
   parameter int ADDR_W    = 23,
   parameter int BLK_SHIFT = 16,
   parameter int CNT_W     = 5
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [ADDR_W-BLK_SHIFT-1:0] blk_ref,
   input  logic [ADDR_W-1:0]           start,
   input  logic [CNT_W-1:0]            limit,
   output logic                        blk_ok,
   output logic                        in_win,
   output logic [CNT_W-1:0]            offset
);
   logic [ADDR_W-1:0] diff;

   always_comb begin
      blk_ok = (addr[ADDR_W-1:BLK_SHIFT] == blk_ref);
      diff   = addr - start;
      in_win = (addr >= start) && (diff <= ADDR_W'(limit));
      offset = diff[CNT_W-1:0];
   end
endmodule

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/fbp_busy_timer.sv
module fbp_busy_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   generate
      if (CYCLES == 1) begin : g_single
         assign done = run;
      end else begin : g_count
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (load)                 cnt_q <= TW'(CYCLES - 1);
            else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign done = run && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
   import fbp_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int BUF_DEPTH   = 32,
   parameter int BLK_SHIFT   = 16,
   parameter int PROG_CYCLES = 64,
   localparam int CNT_W      = $clog2(BUF_DEPTH),
   localparam int BLK_W      = ADDR_W - BLK_SHIFT,
   localparam int NUM_BLK    = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NUM_BLK-1:0] prot_mask,
   input  logic [CNT_W-1:0]  buf_rd_idx,
   output logic [DATA_W-1:0] buf_rd_data,
   output logic [7:0]        status,
   output logic [1:0]        rd_mode,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [CNT_W-1:0]  prog_count
);
   generate
      if (BUF_DEPTH < 2 || (1 << CNT_W) != BUF_DEPTH) begin : g_bad_depth
         $error("BUF_DEPTH must be a power of two of at least 2");
      end
      if (BLK_SHIFT < CNT_W || BLK_SHIFT >= ADDR_W) begin : g_bad_blk
         $error("BLK_SHIFT must cover the buffer and leave block bits");
      end
      if (DATA_W < 8 || BUF_DEPTH > (1 << DATA_W)) begin : g_bad_data
         $error("DATA_W must hold a command byte and the count");
      end
      if (PROG_CYCLES < 1) begin : g_bad_cyc
         $error("PROG_CYCLES must be at least 1");
      end
   endgenerate

   fbp_state_e        state_q;
   fbp_rmode_e        mode_q;
   logic [BLK_W-1:0]  blk_q;
   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  n_q, idx_q;
   logic              err_seq_q, err_prot_q, start_q_pulse;

   logic [7:0]        cmd;
   logic              blk_ok, in_win, first, load_ok, conf_ok, go_prog, t_done;
   logic [CNT_W-1:0]  offset, widx;

   assign cmd     = wr_data[7:0];
   assign first   = (idx_q == '0);
   assign load_ok = blk_ok && (first || in_win);
   assign conf_ok = (cmd == CMD_CONFIRM) && blk_ok;
   assign go_prog = (state_q == ST_CONFIRM) && wr_en && conf_ok && !prot_mask[blk_q];
   assign widx    = first ? '0 : offset;

   fbp_addr_window #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .CNT_W(CNT_W)) u_win (
      .addr(wr_addr), .blk_ref(blk_q), .start(start_q), .limit(n_q),
      .blk_ok(blk_ok), .in_win(in_win), .offset(offset)
   );

   fbp_wbuf #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W), .IDX_W(CNT_W)) u_buf (
      .clk(clk), .we(wr_en && state_q == ST_LOAD && load_ok), .widx(widx),
      .wdata(wr_data), .ridx(buf_rd_idx), .rdata(buf_rd_data)
   );

   fbp_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(go_prog), .run(state_q == ST_BUSY), .done(t_done)
   );

   // read-mode commands shared by the idle and busy phases
   function automatic fbp_rmode_e next_mode(input logic [7:0] c, input fbp_rmode_e cur);
      case (c)
         CMD_ARRAY:  return RM_ARRAY;
         CMD_STATUS: return RM_STATUS;
         CMD_SIGN:   return RM_SIGN;
         CMD_QUERY:  return RM_QUERY;
         default:    return cur;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         mode_q        <= RM_ARRAY;
         blk_q         <= '0;
         start_q       <= '0;
         n_q           <= '0;
         idx_q         <= '0;
         err_seq_q     <= 1'b0;
         err_prot_q    <= 1'b0;
         start_q_pulse <= 1'b0;
      end else begin
         start_q_pulse <= 1'b0;
         case (state_q)
            ST_IDLE: if (wr_en) begin
               if (cmd == CMD_SETUP) begin
                  blk_q   <= wr_addr[ADDR_W-1:BLK_SHIFT];
                  mode_q  <= RM_STATUS;
                  state_q <= ST_COUNT;
               end else if (cmd == CMD_CLEAR) begin
                  err_seq_q  <= 1'b0;
                  err_prot_q <= 1'b0;
               end else begin
                  mode_q <= next_mode(cmd, mode_q);
               end
            end
            ST_COUNT: if (wr_en) begin
               if (!blk_ok || 32'(wr_data) >= BUF_DEPTH) begin
                  err_seq_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  n_q     <= wr_data[CNT_W-1:0];
                  idx_q   <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: if (wr_en) begin
               if (!load_ok) begin
                  err_seq_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  if (first) start_q <= wr_addr;
                  if (idx_q == n_q) state_q <= ST_CONFIRM;
                  else              idx_q   <= idx_q + 1'b1;
               end
            end
            ST_CONFIRM: if (wr_en) begin
               if (!conf_ok) begin
                  err_seq_q <= 1'b1;
                  state_q   <= ST_IDLE;
               end else if (prot_mask[blk_q]) begin
                  err_prot_q <= 1'b1;
                  state_q    <= ST_IDLE;
               end else begin
                  start_q_pulse <= 1'b1;
                  state_q       <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (wr_en) begin
                  if (cmd == CMD_SUSPEND) mode_q <= RM_STATUS;
                  else                    mode_q <= next_mode(cmd, mode_q);
               end
               if (t_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      status           = 8'h00;
      status[SR_READY] = (state_q != ST_BUSY);
      status[SR_SEQ]   = err_seq_q;
      status[SR_PROT]  = err_prot_q;
   end

   assign rd_mode    = mode_q;
   assign prog_start = start_q_pulse;
   assign prog_addr  = start_q;
   assign prog_count = n_q;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
   parameter int ADDR_W      = 23,
   parameter int BLK_SHIFT   = 16,
   parameter int PROG_CYCLES = 64,
   parameter int NUM_BLK     = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_cmd,
   input logic [NUM_BLK-1:0] prot_mask,
   input logic [7:0]        status,
   input logic              prog_start,
   input logic [ADDR_W-1:0] prog_addr
);
   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= 0;
      else if (!status[7]) low_cnt <= low_cnt + 1;
      else                 low_cnt <= 0;
   end

   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);

   p_start_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (!status[7] && $past(status[7])));

   p_fall_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[7]) |-> prog_start);

   p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[7]) |-> (low_cnt == PROG_CYCLES));

   p_no_protected_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !prot_mask[prog_addr[ADDR_W-1:BLK_SHIFT]]);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status[4]) && !($past(wr_en) && $past(wr_cmd) == 8'h50 && $past(status[7])))
      |-> status[4]);

   p_busy_clear_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[7] && wr_en && wr_cmd == 8'h50) |=> (status[4] == $past(status[4])));
endmodule

bind flash_bufprog_seq fbp_checker #(
   .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .PROG_CYCLES(PROG_CYCLES), .NUM_BLK(NUM_BLK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_data[7:0]),
   .prot_mask(prot_mask), .status(status), .prog_start(prog_start), .prog_addr(prog_addr)
);

// File: tb/tb_flash_bufprog_seq.sv
module tb_flash_bufprog_seq;
   localparam int AW = 23, DW = 16, DEPTH = 32, BS = 16, PC = 6, CW = 5, NB = 128;

   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NB-1:0] prot_mask = '0;
   logic [CW-1:0] buf_rd_idx = '0;
   logic [DW-1:0] buf_rd_data;
   logic [7:0]    status;
   logic [1:0]    rd_mode;
   logic          prog_start;
   logic [AW-1:0] prog_addr;
   logic [CW-1:0] prog_count;

   int tests = 0, fails = 0, starts = 0;

   flash_bufprog_seq #(.ADDR_W(AW), .DATA_W(DW), .BUF_DEPTH(DEPTH), .BLK_SHIFT(BS),
                       .PROG_CYCLES(PC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prot_mask(prot_mask), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
      .status(status), .rd_mode(rd_mode), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_count(prog_count));

   always #10 clk = ~clk;

   always @(posedge clk) if (rst_n && prog_start === 1'b1) starts++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [AW-1:0] baddr(input int blk, input int off);
      return AW'((blk << BS) + off);
   endfunction

   function automatic logic [DW-1:0] word(input int n, input int k);
      return DW'(16'h5A00 ^ (n << 8) ^ (k * 13));
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      int cnt;
      logic [AW-1:0] st;
      prot_mask[3] = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 8'h80);
      chk("R1 rd_mode", rd_mode, 0);
      chk("R1 prog_start", prog_start, 0);

      // R10 idle read-mode commands
      wr(baddr(0, 7), 16'h0090); chk("R10 sign", rd_mode, 2);
      wr(baddr(0, 7), 16'h0098); chk("R10 query", rd_mode, 3);
      wr(baddr(0, 7), 16'h0070); chk("R10 status", rd_mode, 1);
      wr(baddr(0, 7), 16'h00FF); chk("R10 array", rd_mode, 0);
      wr(baddr(0, 7), 16'h0012); chk("R10 other ignored", rd_mode, 0);

      // sweep every legal count
      for (int n = 0; n < DEPTH; n++) begin
         int blk = 1 + (n % 2);
         st = baddr(blk, n * 9 + 3);
         wr(baddr(blk, 16'h1234), 16'h00E8);
         chk("R2 setup mode", rd_mode, 1);
         chk("R2 setup ready", status, 8'h80);
         wr(baddr(blk, 0), DW'(n));
         wr(st, word(n, 0));
         for (int k = n; k >= 1; k--) wr(st + AW'(k), word(n, k));
         chk("R4 loaded no error", status, 8'h80);
         wr(baddr(blk, 5), 16'h00D0);
         chk("R5 pulse", prog_start, 1);
         chk("R5 addr", prog_addr, st);
         chk("R5 count", prog_count, n);
         cnt = 0;
         while (status[7] == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) chk("R5 single pulse", prog_start, 0);
         end
         chk("R7 busy length", cnt, PC);
         for (int i = 0; i <= n; i++) begin
            buf_rd_idx = CW'(i);
            #1;
            chk("R4 buffer word", buf_rd_data, word(n, i));
         end
         @(negedge clk);
      end
      chk("R5 start count", starts, DEPTH);

      // R3 oversized count, then sticky error across a program (R9, R8)
      wr(baddr(1, 0), 16'h00E8);
      wr(baddr(1, 0), 16'd32);
      chk("R3 n=32 error", status, 8'h90);
      wr(baddr(1, 0), 16'h00E8);
      wr(baddr(1, 0), 16'd0);
      wr(baddr(1, 40), 16'hBEEF);
      wr(baddr(1, 40), 16'h00D0);
      chk("R9 sticky while busy", status, 8'h10);
      wr(baddr(1, 0), 16'h0090); chk("R8 sign busy", rd_mode, 2);
      wr(baddr(1, 0), 16'h0050); chk("R8 clear ignored busy", status, 8'h10);
      wr(baddr(1, 0), 16'h00E8); chk("R8 setup ignored busy", rd_mode, 2);
      wr(baddr(1, 0), 16'h00B0); chk("R8 suspend busy", rd_mode, 1);
      wr(baddr(1, 0), 16'h00FF); chk("R8 array busy", rd_mode, 0);
      while (status[7] == 1'b0) @(negedge clk);
      chk("R9 sticky after busy", status, 8'h90);
      wr(baddr(1, 0), 16'h0050);
      chk("R9 clear", status, 8'h80);
      chk("R8 one more start", starts, DEPTH + 1);

      // R3 count to a foreign block
      wr(baddr(1, 0), 16'h00E8);
      wr(baddr(2, 0), 16'd3);
      chk("R3 foreign block", status, 8'h90);
      wr(baddr(1, 0), 16'h0050);

      // R4 window edges
      st = baddr(1, 16'h100);
      wr(st, 16'h00E8); wr(st, 16'd3); wr(st, 16'h1111);
      wr(st + 3, 16'h2222);
      chk("R4 upper edge ok", status, 8'h80);
      wr(st + 4, 16'h3333);
      chk("R4 past upper edge", status, 8'h90);
      wr(st, 16'h0050);
      wr(st, 16'h00E8); wr(st, 16'd3); wr(st, 16'h1111);
      wr(st - 1, 16'h4444);
      chk("R4 below start", status, 8'h90);
      wr(st, 16'h0050);

      // R5 bad confirm data and foreign-block confirm
      wr(st, 16'h00E8); wr(st, 16'd0); wr(st, 16'h1111);
      wr(st, 16'h00D1);
      chk("R5 bad confirm", status, 8'h90);
      wr(st, 16'h0050);
      wr(st, 16'h00E8); wr(st, 16'd0); wr(st, 16'h1111);
      wr(baddr(2, 0), 16'h00D0);
      chk("R5 foreign confirm", status, 8'h90);
      wr(st, 16'h0050);

      // R6 protected block
      st = baddr(3, 16'h40);
      wr(st, 16'h00E8); wr(st, 16'd1); wr(st, 16'h1); wr(st + 1, 16'h2);
      wr(st, 16'h00D0);
      chk("R6 protect error", status, 8'h82);
      wr(st, 16'h0050);
      chk("R9 clear both", status, 8'h80);
      repeat (2) @(negedge clk);
      chk("R5 R6 no pulse from aborts", starts, DEPTH + 1);

      summary();
   end
endmodule